// File: doc/BRIEF.md
# Serial Byte Receiver with Latched Framing Error

This block takes an asynchronous serial line and turns each frame into a byte. A frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity bit and no flow control. The bit period is fixed at elaboration time from a clock-frequency parameter and a baud-rate parameter. The number of clock cycles per bit is the integer quotient of the two.

The line passes through a two-flop synchronizer. A high-to-low transition on the idle line starts a frame. The start bit is checked half a bit period later, and each data bit and the stop bit are then sampled one full bit period apart, so every sample falls near the centre of its bit. A good stop bit loads the byte output and raises a one-cycle completion strobe. A start bit that has returned high, or a stop bit that is low, sets an error flag. That flag stays set until reset, and reception of later frames continues normally.

Top module: `uart_rx_sticky`

## Requirements
- R1: After the asynchronous active-low reset, `byte_o` is 0, `done_o` is 0 and `err_o` is 0. The idle line is high.
- R2: For a well-formed frame (low start bit, data bit 0 first through bit 7, high stop bit), `byte_o` equals the transmitted byte once `done_o` is high.
- R3: `done_o` is high for exactly one clock cycle per well-formed frame and never on two consecutive cycles.
- R4: Timing is counted from the clock edge before the line falls, with CYC = CLK_HZ/BAUD and HALF = CYC/2. `done_o` becomes visible exactly 3 + HALF + 9*CYC cycles later: two synchronizer stages plus edge detection, half a bit, then nine full bits.
- R5: If the line is high again at the start-bit centre sample, `err_o` is set, no `done_o` follows, and the receiver returns to idle.
- R6: If the stop bit is sampled low, `err_o` is set, no `done_o` is produced for that frame, and `byte_o` keeps its previous value.
- R7: Once set, `err_o` stays high until `rst_ni` is asserted. Well-formed frames received while it is high are still delivered.
- R8: `byte_o` changes only in a cycle where `done_o` is high, and it otherwise holds the last received byte.
- R9: A frame whose stop bit lasts only HALF+1 cycles before the next start bit is still received, and the following frame is received too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| byte_o | output | DATA_BITS | Last correctly received byte |
| done_o | output | 1 | One-cycle strobe after a good stop-bit sample |
| err_o | output | 1 | Latched framing error (start or stop fault) |

## Verification
The two functions that can meet in one cycle are the completion of one frame and the detection of the next start edge. The receiver returns to idle on the same edge that raises the strobe, while the next falling edge is already passing through the synchronizer. The bench provokes this by shortening the stop bit to HALF+1 cycles before the next start bit. It judges the result by requiring both bytes, in order, each with its strobe on the exact cycle R4 predicts, and no error.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
  parameter int CYC  = 16,
  parameter int HALF = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic half_i,
  output logic tick_o
);
  localparam int W = $clog2(CYC + 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;

  assign lim    = half_i ? W'(HALF - 1) : W'(CYC - 1);
  assign tick_o = !clr_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + W'(1);
  end

  // R4
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(CYC - 1));
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          bit_i,
  input  logic          load_i,
  output logic [DW-1:0] byte_o
);
  logic [DW-1:0] sh_q;
  logic [DW-1:0] byte_q;

  // lsb arrives first: shift toward bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {bit_i, sh_q[DW-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     byte_q <= '0;
    else if (load_i) byte_q <= sh_q;
  end

  assign byte_o = byte_q;
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int BAUD      = 115_200,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_i,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 done_o,
  output logic                 err_o
);
  import uart_rx_pkg::*;

  localparam int CYC  = CLK_HZ / BAUD;
  localparam int HALF = CYC / 2;
  localparam int BW   = $clog2(DATA_BITS);

  rx_state_e     state_q;
  logic [BW-1:0] bit_q;
  logic          rx_s, rx_prev_q, fall;
  logic          tick;
  logic          done_q, err_q;
  logic          shift_en, load_en;

  uart_rx_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_prev_q <= 1'b1;
    else         rx_prev_q <= rx_s;
  end
  assign fall = rx_prev_q && !rx_s;

  uart_rx_timer #(.CYC(CYC), .HALF(HALF)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q == ST_IDLE),
    .half_i(state_q == ST_START),
    .tick_o(tick)
  );

  assign shift_en = (state_q == ST_DATA) && tick;
  assign load_en  = (state_q == ST_STOP) && tick && rx_s;

  uart_rx_shift #(.DW(DATA_BITS)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en),
    .bit_i  (rx_s),
    .load_i (load_en),
    .byte_o (byte_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fall) state_q <= ST_START;
        ST_START: if (tick) begin
          if (rx_s) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            bit_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (tick) begin
          if (bit_q == BW'(DATA_BITS - 1)) state_q <= ST_STOP;
          else                             bit_q   <= bit_q + BW'(1);
        end
        ST_STOP: if (tick) begin
          if (rx_s) done_q <= 1'b1;
          else      err_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R8
  byte_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_o != $past(byte_o)) |-> done_o);

  // R5
  start_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick && rx_s) |=> (err_o && !done_o));

  // R6
  stop_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && tick && !rx_s) |=> (err_o && !done_o));
endmodule

// File: tb/tb_uart_rx_sticky.sv
module tb_uart_rx_sticky;
  localparam int CLK_HZ = 50_000_000;
  localparam int BAUD   = 3_125_000;
  localparam int CYC    = CLK_HZ / BAUD;
  localparam int HALF   = CYC / 2;
  localparam int LAT    = 3 + HALF + 9 * CYC;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [7:0] byte_o;
  logic       done_o, err_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic       done_prev = 1'b0;
  logic [7:0] exp_q[$];
  int         t_q[$];

  uart_rx_sticky #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_BITS(8)) dut (
    .clk_i (clk),
    .rst_ni(rst_n),
    .rx_i  (rx),
    .byte_o(byte_o),
    .done_o(done_o),
    .err_o (err_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        check(!done_prev, "R3 strobe width", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R5/R6 unexpected strobe", byte_o, 0);
        end else begin
          logic [7:0] e;
          int t;
          e = exp_q.pop_front();
          t = t_q.pop_front();
          check(byte_o == e, "R2 byte", byte_o, e);
          check(cyc - t == LAT, "R4 strobe cycle", cyc - t, LAT);
        end
      end
      done_prev = done_o;
    end else begin
      done_prev = 1'b0;
    end
  end

  task automatic send(input logic [7:0] b, input int stop_len, input bit stop_ok, input bit expect_ok);
    @(negedge clk);
    rx = 1'b0;
    if (expect_ok) begin
      exp_q.push_back(b);
      t_q.push_back(cyc);
    end
    repeat (CYC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (CYC) @(negedge clk);
    end
    rx = stop_ok;
    repeat (stop_len) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check(byte_o == 8'h00, "R1 byte after reset", byte_o, 0);
    check(done_o == 1'b0, "R1 done after reset", done_o, 0);
    check(err_o == 1'b0, "R1 err after reset", err_o, 0);

    // R2 R4 several patterns
    send(8'hA5, CYC, 1'b1, 1'b1); idle(CYC);
    send(8'h3C, CYC, 1'b1, 1'b1); idle(3);
    send(8'h00, CYC, 1'b1, 1'b1); idle(CYC);
    send(8'hFF, CYC, 1'b1, 1'b1); idle(7);
    send(8'h81, CYC, 1'b1, 1'b1); idle(2 * CYC);
    check(err_o == 1'b0, "R2 no error on clean frames", err_o, 0);

    // R8 hold
    idle(5 * CYC);
    check(byte_o == 8'h81, "R8 byte held", byte_o, 8'h81);

    // R9 back-to-back with short stop
    send(8'h5A, HALF, 1'b1, 1'b1);
    send(8'hC3, HALF, 1'b1, 1'b1);
    idle(2 * CYC);
    check(err_o == 1'b0, "R9 no error back-to-back", err_o, 0);
    check(exp_q.size() == 0, "R9 both frames delivered", exp_q.size(), 0);

    // R5 start glitch
    @(negedge clk);
    rx = 1'b0;
    idle(3);
    rx = 1'b1;
    idle(3 * CYC);
    check(err_o == 1'b1, "R5 start fault latched", err_o, 1);
    check(byte_o == 8'hC3, "R5 byte unchanged", byte_o, 8'hC3);

    // R7 sticky while still receiving
    send(8'h96, CYC, 1'b1, 1'b1);
    idle(2 * CYC);
    check(err_o == 1'b1, "R7 err stays set", err_o, 1);
    check(byte_o == 8'h96, "R7 frame delivered with err set", byte_o, 8'h96);
    do_reset();
    check(err_o == 1'b0, "R7 err cleared by reset", err_o, 0);
    check(byte_o == 8'h00, "R1 byte cleared by reset", byte_o, 0);

    // R6 stop fault
    send(8'h77, CYC, 1'b0, 1'b0);
    idle(2 * CYC);
    check(err_o == 1'b1, "R6 stop fault latched", err_o, 1);
    check(byte_o == 8'h00, "R6 byte unchanged", byte_o, 0);

    // R3 every good frame produced a strobe
    check(exp_q.size() == 0, "R3 all strobes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule